// File: doc/BRIEF.md
# Manchester II Serial Word Receiver

This receiver takes a Manchester II coded serial stream sampled by a clock running at twelve times the bit rate. The stream arrives either as a complementary differential pair, where one wire high and the other low carries a level and an equal pair means no signal, or as one single-ended line that carries the coded waveform directly. The block hunts continuously for a sync pattern lasting three bit times: one level for a bit and a half, then the opposite level for a bit and a half. A sync that starts high marks a command word. A sync that starts low marks a data word.

After a sync, the receiver slices sixteen data bits and one parity bit by sampling each half of every bit cell. It streams the data bits out in NRZ form, together with a take-data window and a shift clock whose rising edge falls in the middle of each stable bit. When the word ends, a one-clock flag reports an error-free word with odd parity. A bit cell with no mid-bit transition, or a loss of signal on the differential pair, aborts the word and puts the receiver back into sync hunting.

Top module: `mdec_word_rx`

## Requirements
- R1: With `line_sel`=0 the pair (`bip_one`,`bip_zero`)=(1,0) reads as high, (0,1) reads as low, and an equal pair reads as no signal. With `line_sel`=1 the level of `uni_data` is used and is always valid.
- R2: A run of one valid level lasting 16 to 20 clocks, followed directly by the opposite valid level, is taken as a sync. A run of 15 clocks or fewer, or 21 clocks or more, is not.
- R3: `cmd_sync` is 1 after a high-first sync and 0 after a low-first sync. It updates 3 clocks after the first sample of the second sync half is applied, holds its value through the word, and clears when the word ends or is aborted.
- R4: Each bit's value is the level of its first half (1 = high then low). The bits appear on `sdata` in arrival order, 12 clocks each, with the first bit 27 clocks after the `cmd_sync` update. `take_data` is high from the first bit until the word ends. `sdata` is 0 whenever `take_data` is low.
- R5: `shift_clk` is low when `sdata` changes and rises 6 clocks later for 6 clocks. It is active only while `take_data` is high, which gives 16 rising edges per word.
- R6: The 17th bit is parity. 219 clocks after the `cmd_sync` update, `take_data`, `cmd_sync` and `sdata` drop together. At that same clock `word_ok` rises only when the count of ones over all 17 bits is odd.
- R7: `word_ok` is high for exactly one clock.
- R8: If a bit cell has equal levels at its two sample points, or no signal at either of them, all outputs go low in the following clock, no `word_ok` is given for that word, and sync hunting resumes.
- R9: A synchronous reset clears every output on the next clock and returns the receiver to sync hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 12 times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| line_sel | input | 1 | 0 selects the differential pair, 1 selects the single-ended line |
| bip_one | input | 1 | Differential pair, true wire |
| bip_zero | input | 1 | Differential pair, complement wire |
| uni_data | input | 1 | Single-ended coded line |
| cmd_sync | output | 1 | Sync type of the current word, 1 = command |
| take_data | output | 1 | Window in which decoded bits are presented |
| shift_clk | output | 1 | Bit clock for `sdata`, rising at mid-bit |
| sdata | output | 1 | Decoded data bits, NRZ |
| word_ok | output | 1 | One-clock flag for an error-free word with odd parity |

## Verification
The assertions assume that `rst` is high at the first clock edge. They also assume that any word which ends normally has been framed by a real sync, so that `take_data` was high in the clock before `word_ok`. The stimulus meets these assumptions because it starts in reset. It also places single-ended idle gaps of 30 clocks and chooses the idle level opposite to the first sync half, so that the level change into a gap cannot form a false 16 to 20 clock run. The error words are chosen so that the held bit cell does not merge with a neighbouring half into a sync-length run.

// File: rtl/mdec_pkg.sv
`timescale 1ns/1ps
package mdec_pkg;
   typedef enum logic [1:0] {
      ST_HUNT  = 2'd0,
      ST_SYNC2 = 2'd1,
      ST_BITS  = 2'd2
   } mdec_state_t;
endpackage

// File: rtl/mdec_front.sv
`timescale 1ns/1ps
module mdec_front #(
   parameter int IN_FLOPS = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic line_sel,
   input  logic bip_one,
   input  logic bip_zero,
   input  logic uni_data,
   output logic ln,
   output logic ln_vld
);
   logic raw_lvl;
   logic raw_vld;

   always_comb begin
      raw_lvl = line_sel ? uni_data : (bip_one & ~bip_zero);
      raw_vld = line_sel | (bip_one ^ bip_zero);
   end

   generate
      if (IN_FLOPS == 1) begin : g_single
         logic lv_q, vd_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               lv_q <= 1'b0;
               vd_q <= 1'b0;
            end else begin
               lv_q <= raw_lvl;
               vd_q <= raw_vld;
            end
         end
         assign ln     = lv_q;
         assign ln_vld = vd_q;
      end else begin : g_chain
         logic [IN_FLOPS-1:0] lv_p, vd_p;
         always_ff @(posedge clk) begin
            if (rst) begin
               lv_p <= '0;
               vd_p <= '0;
            end else begin
               lv_p <= {lv_p[IN_FLOPS-2:0], raw_lvl};
               vd_p <= {vd_p[IN_FLOPS-2:0], raw_vld};
            end
         end
         assign ln     = lv_p[IN_FLOPS-1];
         assign ln_vld = vd_p[IN_FLOPS-1];
      end
   endgenerate
endmodule

// File: rtl/mdec_sync_hunt.sv
`timescale 1ns/1ps
module mdec_sync_hunt #(
   parameter int RUN_LO = 16,
   parameter int RUN_HI = 20
) (
   input  logic clk,
   input  logic rst,
   input  logic ln,
   input  logic ln_vld,
   output logic sync_hit,
   output logic sync_first
);
   localparam int RUNW = $clog2(RUN_HI + 2);
   localparam logic [RUNW-1:0] RUN_MAX = RUNW'(RUN_HI + 1);
   localparam logic [RUNW-1:0] LO_V    = RUNW'(RUN_LO);
   localparam logic [RUNW-1:0] HI_V    = RUNW'(RUN_HI);

   logic            ln_q;
   logic            vld_q;
   logic [RUNW-1:0] run;

   always_ff @(posedge clk) begin
      if (rst) begin
         ln_q  <= 1'b0;
         vld_q <= 1'b0;
         run   <= '0;
      end else begin
         ln_q  <= ln;
         vld_q <= ln_vld;
         if (!ln_vld)
            run <= '0;
         else if (!vld_q || (ln != ln_q))
            run <= RUNW'(1);
         else if (run != RUN_MAX)
            run <= run + 1'b1;
      end
   end

   always_comb begin
      sync_first = ln_q;
      sync_hit   = ln_vld && vld_q && (ln != ln_q) && (run >= LO_V) && (run <= HI_V);
   end
endmodule

// File: rtl/mdec_bit_slicer.sv
`timescale 1ns/1ps
module mdec_bit_slicer
   import mdec_pkg::*;
#(
   parameter int OVS       = 12,
   parameter int NBITS     = 16,
   parameter int SYNC_HALF = 18,
   parameter int SYNC_TOL  = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic ln,
   input  logic ln_vld,
   input  logic sync_hit,
   input  logic sync_first,
   output logic cmd_sync,
   output logic take_data,
   output logic shift_clk,
   output logic sdata,
   output logic word_ok
);
   localparam int HALF = OVS / 2;
   localparam int PHW  = $clog2(OVS);
   localparam int IDXW = $clog2(NBITS + 1);
   localparam int PCW  = $clog2(SYNC_HALF + 1);
   localparam logic [PHW-1:0]  PH_S1   = PHW'(OVS / 4);
   localparam logic [PHW-1:0]  PH_S2   = PHW'(OVS / 4 + HALF);
   localparam logic [PHW-1:0]  PH_LAST = PHW'(OVS - 1);
   localparam logic [IDXW-1:0] IDX_PAR = IDXW'(NBITS);
   localparam logic [PCW-1:0]  PC_CHK  = PCW'(SYNC_HALF - SYNC_TOL);
   localparam logic [PCW-1:0]  PC_LAST = PCW'(SYNC_HALF - 1);

   mdec_state_t     st;
   logic [PCW-1:0]  pcnt;
   logic [PHW-1:0]  ph;
   logic [IDXW-1:0] bidx;
   logic            h1, h1_ok, par;
   logic            cmd_q, take_q, sdat_q, ok_q;
   logic            cell_bad;

   assign cell_bad = !h1_ok || !ln_vld || (ln == h1);

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= ST_HUNT;
         pcnt   <= '0;
         ph     <= '0;
         bidx   <= '0;
         h1     <= 1'b0;
         h1_ok  <= 1'b0;
         par    <= 1'b0;
         cmd_q  <= 1'b0;
         take_q <= 1'b0;
         sdat_q <= 1'b0;
         ok_q   <= 1'b0;
      end else begin
         ok_q <= 1'b0;
         unique case (st)
            ST_HUNT: begin
               if (sync_hit) begin
                  st    <= ST_SYNC2;
                  pcnt  <= PCW'(1);
                  cmd_q <= sync_first;
                  par   <= 1'b0;
               end
            end
            ST_SYNC2: begin
               if ((pcnt < PC_CHK) && (!ln_vld || (ln == cmd_q))) begin
                  st    <= ST_HUNT;
                  cmd_q <= 1'b0;
               end else if (pcnt == PC_LAST) begin
                  st   <= ST_BITS;
                  ph   <= '0;
                  bidx <= '0;
               end else begin
                  pcnt <= pcnt + 1'b1;
               end
            end
            ST_BITS: begin
               if (ph == PH_LAST) begin
                  ph   <= '0;
                  bidx <= bidx + 1'b1;
               end else begin
                  ph <= ph + 1'b1;
               end
               if (ph == PH_S1) begin
                  h1    <= ln;
                  h1_ok <= ln_vld;
               end
               if (ph == PH_S2) begin
                  if (cell_bad) begin
                     st     <= ST_HUNT;
                     cmd_q  <= 1'b0;
                     take_q <= 1'b0;
                     sdat_q <= 1'b0;
                  end else if (bidx != IDX_PAR) begin
                     sdat_q <= h1;
                     take_q <= 1'b1;
                     par    <= par ^ h1;
                  end else begin
                     ok_q   <= par ^ h1;
                     st     <= ST_HUNT;
                     cmd_q  <= 1'b0;
                     take_q <= 1'b0;
                     sdat_q <= 1'b0;
                  end
               end
            end
            default: st <= ST_HUNT;
         endcase
      end
   end

   always_comb begin
      cmd_sync  = cmd_q;
      take_data = take_q;
      sdata     = sdat_q;
      word_ok   = ok_q;
      shift_clk = take_q && (ph > PH_S1) && (ph <= PH_S2);
   end
endmodule

// File: rtl/mdec_word_rx.sv
`timescale 1ns/1ps
module mdec_word_rx #(
   parameter int OVS      = 12,
   parameter int NBITS    = 16,
   parameter int SYNC_TOL = 2,
   parameter int IN_FLOPS = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic line_sel,
   input  logic bip_one,
   input  logic bip_zero,
   input  logic uni_data,
   output logic cmd_sync,
   output logic take_data,
   output logic shift_clk,
   output logic sdata,
   output logic word_ok
);
   localparam int SYNC_HALF = (3 * OVS) / 2;

   generate
      if ((OVS % 4) != 0 || OVS < 8) begin : g_bad_ovs
         $error("OVS must be a multiple of 4 and at least 8");
      end
      if (IN_FLOPS < 1) begin : g_bad_flops
         $error("IN_FLOPS must be at least 1");
      end
      if (SYNC_TOL < 0 || SYNC_TOL >= OVS / 2) begin : g_bad_tol
         $error("SYNC_TOL must keep sync runs apart from data runs");
      end
      if (NBITS < 1) begin : g_bad_nbits
         $error("NBITS must be positive");
      end
   endgenerate

   logic ln, ln_vld, sync_hit, sync_first;

   mdec_front #(.IN_FLOPS(IN_FLOPS)) u_front (
      .clk(clk), .rst(rst), .line_sel(line_sel), .bip_one(bip_one),
      .bip_zero(bip_zero), .uni_data(uni_data), .ln(ln), .ln_vld(ln_vld)
   );

   mdec_sync_hunt #(
      .RUN_LO(SYNC_HALF - SYNC_TOL), .RUN_HI(SYNC_HALF + SYNC_TOL)
   ) u_hunt (
      .clk(clk), .rst(rst), .ln(ln), .ln_vld(ln_vld),
      .sync_hit(sync_hit), .sync_first(sync_first)
   );

   mdec_bit_slicer #(
      .OVS(OVS), .NBITS(NBITS), .SYNC_HALF(SYNC_HALF), .SYNC_TOL(SYNC_TOL)
   ) u_slicer (
      .clk(clk), .rst(rst), .ln(ln), .ln_vld(ln_vld),
      .sync_hit(sync_hit), .sync_first(sync_first),
      .cmd_sync(cmd_sync), .take_data(take_data), .shift_clk(shift_clk),
      .sdata(sdata), .word_ok(word_ok)
   );
endmodule

// File: rtl/mdec_word_rx_chk.sv
`timescale 1ns/1ps
module mdec_word_rx_chk (
   input logic clk,
   input logic rst,
   input logic cmd_sync,
   input logic take_data,
   input logic shift_clk,
   input logic sdata,
   input logic word_ok
);
   p_ok_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      word_ok |=> !word_ok);

   p_ok_end_r6: assert property (@(posedge clk) disable iff (rst)
      word_ok |-> (!take_data && $past(take_data)));

   p_clk_gate_r5: assert property (@(posedge clk) disable iff (rst)
      shift_clk |-> take_data);

   p_sdata_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (shift_clk && $past(shift_clk)) |-> $stable(sdata));

   p_sdata_idle_r4: assert property (@(posedge clk) disable iff (rst)
      !take_data |-> !sdata);

   p_cmd_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (take_data && $past(take_data)) |-> $stable(cmd_sync));

   p_rst_clear_r9: assert property (@(posedge clk)
      rst |=> (!cmd_sync && !take_data && !shift_clk && !sdata && !word_ok));
endmodule

bind mdec_word_rx mdec_word_rx_chk i_chk (
   .clk(clk), .rst(rst), .cmd_sync(cmd_sync), .take_data(take_data),
   .shift_clk(shift_clk), .sdata(sdata), .word_ok(word_ok)
);

// File: tb/test_mdec_word_rx.sv
`timescale 1ns/1ps
module test_mdec_word_rx;
   localparam int MAXC = 7000;
   localparam int LAT  = 3;

   logic clk = 1'b0;
   logic rst, line_sel, bip_one, bip_zero, uni_data;
   logic cmd_sync, take_data, shift_clk, sdata, word_ok;

   bit        d_one [MAXC];
   bit        d_zero[MAXC];
   bit        d_uni [MAXC];
   bit        d_sel [MAXC];
   bit        d_rst [MAXC];
   bit  [4:0] expv  [MAXC];
   int        tg    [MAXC];

   int  cur = 0;
   bit  mode = 1'b0;
   int  total = 0;
   int  bad = 0;
   int  cyc = 0;
   bit  done = 1'b0;
   int  last_c;

   mdec_word_rx i_mdec_word_rx (
      .clk(clk), .rst(rst), .line_sel(line_sel), .bip_one(bip_one),
      .bip_zero(bip_zero), .uni_data(uni_data), .cmd_sync(cmd_sync),
      .take_data(take_data), .shift_clk(shift_clk), .sdata(sdata),
      .word_ok(word_ok)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic string fname(int f);
      case (f)
         4: return "cmd_sync";
         3: return "take_data";
         2: return "shift_clk";
         1: return "sdata";
         default: return "word_ok";
      endcase
   endfunction

   function automatic string freq(int f);
      case (f)
         4: return "R3";
         3: return "R4";
         2: return "R5";
         1: return "R4";
         default: return "R6/R7";
      endcase
   endfunction

   task automatic put(input bit lvl, input bit vld, input int n, input int t);
      for (int i = 0; i < n; i++) begin
         d_sel[cur]  = mode;
         d_one[cur]  = !mode && lvl && vld;
         d_zero[cur] = !mode && !lvl && vld;
         d_uni[cur]  = mode && lvl;
         tg[cur]     = t;
         cur++;
      end
   endtask

   task automatic gap(input int n, input bit lvl, input int t);
      put(lvl, mode, n, t);
   endtask

   task automatic setx(input int c, input int f, input bit v, input int t);
      expv[c][f] = v;
      tg[c]      = t;
   endtask

   // Builds one word on the line and its expected output waveform.
   task automatic frame(input bit cmdb, input logic [15:0] d, input bit pflip,
                        input int h1, input int ek, input bit ekinv,
                        input int t, output int en);
      int  s, b0;
      bit  pb, bv;
      s  = cur;
      pb = ~(^d) ^ pflip;
      put(cmdb, 1'b1, h1, t);
      put(~cmdb, 1'b1, 18, t);
      for (int k = 0; k <= 16; k++) begin
         bv = (k < 16) ? d[15-k] : pb;
         if (k == ek) put(bv, !ekinv, 12, t);
         else begin
            put(bv, 1'b1, 6, t);
            put(~bv, 1'b1, 6, t);
         end
      end
      b0 = s + h1 + LAT;
      en = (ek >= 0) ? b0 + 27 + 12 * ek : b0 + 219;
      for (int c = b0; c < en; c++) setx(c, 4, cmdb, t);
      for (int c = b0 + 27; c < en; c++) setx(c, 3, 1'b1, t);
      for (int k = 0; k < 16; k++) begin
         if (b0 + 27 + 12 * k < en) begin
            for (int c = b0 + 27 + 12 * k; c < b0 + 39 + 12 * k && c < en; c++)
               setx(c, 1, d[15-k], t);
            for (int c = b0 + 33 + 12 * k; c < b0 + 39 + 12 * k && c < en; c++)
               setx(c, 2, 1'b1, t);
         end
      end
      if (ek < 0 && !pflip) setx(en, 0, 1'b1, t);
   endtask

   task automatic run_sched();
      forever begin
         @(negedge clk);
         if (cyc >= 1) begin
            logic [4:0] got;
            got = {cmd_sync, take_data, shift_clk, sdata, word_ok};
            for (int f = 4; f >= 0; f--) begin
               total++;
               if (got[f] !== expv[cyc][f]) begin
                  bad++;
                  $display("FAIL %s (case R%0d) cyc=%0d %s got %b exp %b",
                           freq(f), tg[cyc], cyc, fname(f), got[f], expv[cyc][f]);
               end
            end
         end
         if (cyc >= last_c) break;
         rst      = d_rst[cyc];
         line_sel = d_sel[cyc];
         bip_one  = d_one[cyc];
         bip_zero = d_zero[cyc];
         uni_data = d_uni[cyc];
      end
   endtask

   initial begin
      int en, s, r;
      for (int c = 0; c < MAXC; c++) begin
         expv[c] = '0; d_rst[c] = 1'b0; tg[c] = 0;
      end
      // R9: reset state at start
      for (int c = 0; c < 6; c++) d_rst[c] = 1'b1;
      mode = 1'b0;
      gap(20, 1'b0, 9);
      // R3 R4 R5 R6: command word, then data word, differential input
      frame(1'b1, 16'hA5C3, 1'b0, 18, -1, 1'b0, 3, en); gap(20, 1'b0, 3);
      frame(1'b0, 16'h1234, 1'b0, 18, -1, 1'b0, 4, en); gap(20, 1'b0, 4);
      // R2: first-half length at both tolerance limits
      frame(1'b1, 16'hFFFF, 1'b0, 16, -1, 1'b0, 2, en); gap(20, 1'b0, 2);
      frame(1'b0, 16'h8001, 1'b0, 20, -1, 1'b0, 2, en); gap(20, 1'b0, 2);
      // R2: lengths just outside the tolerance are ignored
      put(1'b1, 1'b1, 15, 2); put(1'b0, 1'b1, 18, 2); gap(30, 1'b0, 2);
      put(1'b0, 1'b1, 21, 2); put(1'b1, 1'b1, 18, 2); gap(30, 1'b0, 2);
      // R6: parity error gives no word_ok
      frame(1'b1, 16'h00FF, 1'b1, 18, -1, 1'b0, 6, en); gap(20, 1'b0, 6);
      // R8: missing mid-bit transition in a data bit and in the parity bit
      frame(1'b1, 16'hFDFF, 1'b0, 18, 5, 1'b0, 8, en); gap(20, 1'b0, 8);
      frame(1'b0, 16'h0003, 1'b0, 18, 16, 1'b0, 8, en); gap(20, 1'b0, 8);
      // R1 R8: equal differential pair inside a bit cell
      frame(1'b1, 16'h5555, 1'b0, 18, 9, 1'b1, 1, en); gap(20, 1'b0, 1);
      // R9: reset in the middle of a word
      s = cur;
      frame(1'b0, 16'h3C3C, 1'b0, 18, -1, 1'b0, 9, en);
      r = s + 100;
      for (int c = r; c < r + 3; c++) d_rst[c] = 1'b1;
      for (int c = r + 1; c <= en + 2; c++) setx(c, 0, 1'b0, 9);
      for (int c = r + 1; c <= en + 2; c++) expv[c] = '0;
      gap(20, 1'b0, 9);
      // R1: single-ended input, command then data word
      mode = 1'b1;
      gap(30, 1'b0, 1);
      frame(1'b1, 16'hBEEF, 1'b0, 18, -1, 1'b0, 1, en);
      gap(30, 1'b1, 1);
      frame(1'b0, 16'h0F0F, 1'b0, 18, -1, 1'b0, 1, en);
      gap(40, 1'b1, 1);
      last_c = cur;

      rst = 1'b1; line_sel = 1'b0; bip_one = 1'b0; bip_zero = 1'b0; uni_data = 1'b0;
      run_sched();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         bad++;
         $display("FAIL R4 watchdog got cyc=%0d exp end by cyc=%0d", cyc, last_c);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule